// File: doc/BRIEF.md
# Two-Word Transmit/Receive Buffer Pair with Sticky Error Flags

This block sits between a host bus and a serial shift engine. It holds two small first-in first-out buffers, each exactly two words deep. The receive buffer is filled by the shifter and drained by the host. The transmit buffer is filled by the host and drained by the shifter. Full and empty flags for both buffers are exported so that the host and the shifter can pace themselves.

When the shifter delivers a word while the receive buffer is already full, the word is dropped, the two stored words are kept, and a sticky read-error flag is raised. When the shifter asks for a word while the transmit buffer is empty, the word it received last is presented again and a sticky write-error flag is raised. The host clears either flag with a write-one-to-clear access that carries a two-bit mask.

Both data outputs are registered. Each updates in the cycle after a successful pop and holds its value otherwise. The word width and the buffer depth are parameters. The depth defaults to two.

Top module: `xfer_buffer_pair`

## Requirements
- R1: Each buffer returns words in the order they were accepted. `rxFull`/`txFull` are 1 when the buffer holds two words and `rxEmpty`/`txEmpty` are 1 when it holds none. All four flags update in the cycle after the push or pop.
- R2: A `shRxPush` while `rxFull` is 1 (fullness taken at the start of the cycle, even if the host pops in the same cycle) drops the incoming word and leaves the stored words and their order unchanged. `rdErr` reads 1 from the next cycle on.
- R3: A `hostTxPush` while `txFull` is 1 drops the word, does not change the transmit buffer, and does not raise any error flag.
- R4: A `shTxPop` while `txEmpty` is 1 leaves `shTxData` at its previous value and makes `wrErr` read 1 from the next cycle on. A word the host pushes in that same cycle is stored in the buffer.
- R5: A `shTxPop` while `txEmpty` is 0 loads the oldest transmit word onto `shTxData` in the next cycle. `shTxData` holds that value until the next pop.
- R6: A `hostRxPop` while `rxEmpty` is 0 loads the oldest receive word onto `hostRxData` in the next cycle. A pop while `rxEmpty` is 1 leaves `hostRxData` and the buffer unchanged.
- R7: `rdErr` and `wrErr` are sticky. When `hostStatClr` is 1, bit 0 of `hostStatClrMask` clears `rdErr` and bit 1 clears `wrErr`. A new error in the same cycle as its clear leaves the flag set.
- R8: After reset both buffers are empty and not full, both error flags are 0, and `hostRxData` and `shTxData` are 0.
- R9: A push and a pop on the same buffer in the same cycle, while it is neither full nor empty, keeps its occupancy and order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hostTxPush | input | 1 | Host writes a transmit word |
| hostTxData | input | W | Transmit word from host |
| hostRxPop | input | 1 | Host takes a receive word |
| hostRxData | output | W | Receive word most recently taken by host |
| shRxPush | input | 1 | Shifter delivers a received word |
| shRxData | input | W | Received word from shifter |
| shTxPop | input | 1 | Shifter requests the next transmit word |
| shTxData | output | W | Transmit word most recently given to shifter |
| hostStatClr | input | 1 | Host write-one-to-clear strobe for error flags |
| hostStatClrMask | input | 2 | Bit 0 clears rdErr, bit 1 clears wrErr |
| rxFull | output | 1 | Receive buffer holds two words |
| rxEmpty | output | 1 | Receive buffer holds no words |
| txFull | output | 1 | Transmit buffer holds two words |
| txEmpty | output | 1 | Transmit buffer holds no words |
| rdErr | output | 1 | Sticky receive overflow flag |
| wrErr | output | 1 | Sticky transmit underflow flag |

## Verification
The assertions check cycle-local rules on every cycle: an overflow raises `rdErr` and leaves the receive buffer full, an underflow raises `wrErr` and holds `shTxData`, the flags stay set until a masked clear, and an empty host pop holds `hostRxData`. Other behaviour spans many cycles and only the bench's scenarios can show it. This covers first-in first-out order across wrap-around, the survival of the two stored words after a dropped overflow word, and the silent drop of a host push into a full transmit buffer, which is only visible in the words later popped. The bench compares every output on every cycle against a queue-based model. The stimulus is directed corner cases followed by seeded random traffic.

// File: rtl/xfer_buf_pkg.sv
package xfer_buf_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic rxWe;   // store shRxData at the receive write pointer
    logic rxRe;   // load hostRxData from the receive read pointer
    logic txWe;   // store hostTxData at the transmit write pointer
    logic txRe;   // load shTxData from the transmit read pointer
  } bufStrobe_t;

  localparam int LANE_RX = 0;
  localparam int LANE_TX = 1;
  localparam int NUM_LANES = 2;
endpackage

// File: rtl/xfer_buf_ctrl.sv
module xfer_buf_ctrl
  import xfer_buf_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hostTxPush,
  input  logic             hostRxPop,
  input  logic             shRxPush,
  input  logic             shTxPop,
  input  logic             hostStatClr,
  input  logic [1:0]       hostStatClrMask,
  output bufStrobe_t       stb,
  output logic [PTR_W-1:0] rxWrPtr,
  output logic [PTR_W-1:0] rxRdPtr,
  output logic [PTR_W-1:0] txWrPtr,
  output logic [PTR_W-1:0] txRdPtr,
  output logic             rxFull,
  output logic             rxEmpty,
  output logic             txFull,
  output logic             txEmpty,
  output logic             rdErr,
  output logic             wrErr
);
  logic [NUM_LANES-1:0]             pushReq, popReq, fullQ, emptyQ, accept, take;
  logic [NUM_LANES-1:0][PTR_W-1:0] wrP, rdP;
  logic rdErrQ, wrErrQ, rxOvf, txUnd;

  assign pushReq[LANE_RX] = shRxPush;
  assign pushReq[LANE_TX] = hostTxPush;
  assign popReq[LANE_RX]  = hostRxPop;
  assign popReq[LANE_TX]  = shTxPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar d = 0; d < NUM_LANES; d++) begin : g_lane
    logic [CNT_W-1:0] cntQ;
    logic [PTR_W-1:0] wrQ, rdQ;

    assign fullQ[d]  = (cntQ == CNT_W'(DEPTH));
    assign emptyQ[d] = (cntQ == '0);
    assign accept[d] = pushReq[d] && !fullQ[d];
    assign take[d]   = popReq[d] && !emptyQ[d];
    assign wrP[d]    = wrQ;
    assign rdP[d]    = rdQ;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cntQ <= '0;
        wrQ  <= '0;
        rdQ  <= '0;
      end else begin
        if (accept[d]) wrQ <= nextPtr(wrQ);
        if (take[d])   rdQ <= nextPtr(rdQ);
        case ({accept[d], take[d]})
          2'b10:   cntQ <= cntQ + CNT_W'(1);
          2'b01:   cntQ <= cntQ - CNT_W'(1);
          default: cntQ <= cntQ;
        endcase
      end
    end
  end

  assign rxOvf = shRxPush && fullQ[LANE_RX];
  assign txUnd = shTxPop && emptyQ[LANE_TX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdErrQ <= 1'b0;
      wrErrQ <= 1'b0;
    end else begin
      rdErrQ <= rxOvf || (rdErrQ && !(hostStatClr && hostStatClrMask[0]));
      wrErrQ <= txUnd || (wrErrQ && !(hostStatClr && hostStatClrMask[1]));
    end
  end

  assign stb.rxWe = accept[LANE_RX];
  assign stb.rxRe = take[LANE_RX];
  assign stb.txWe = accept[LANE_TX];
  assign stb.txRe = take[LANE_TX];

  assign rxWrPtr = wrP[LANE_RX];
  assign rxRdPtr = rdP[LANE_RX];
  assign txWrPtr = wrP[LANE_TX];
  assign txRdPtr = rdP[LANE_TX];
  assign rxFull  = fullQ[LANE_RX];
  assign rxEmpty = emptyQ[LANE_RX];
  assign txFull  = fullQ[LANE_TX];
  assign txEmpty = emptyQ[LANE_TX];
  assign rdErr   = rdErrQ;
  assign wrErr   = wrErrQ;
endmodule

// File: rtl/xfer_buf_data.sv
module xfer_buf_data
  import xfer_buf_pkg::*;
#(
  parameter int W = 32,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bufStrobe_t       stb,
  input  logic [PTR_W-1:0] rxWrPtr,
  input  logic [PTR_W-1:0] rxRdPtr,
  input  logic [PTR_W-1:0] txWrPtr,
  input  logic [PTR_W-1:0] txRdPtr,
  input  logic [W-1:0]     shRxData,
  input  logic [W-1:0]     hostTxData,
  output logic [W-1:0]     hostRxData,
  output logic [W-1:0]     shTxData
);
  logic [W-1:0] rxMem [DEPTH];
  logic [W-1:0] txMem [DEPTH];
  logic [W-1:0] lastRead, lastSent;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (stb.rxWe && rxWrPtr == PTR_W'(i)) rxMem[i] <= shRxData;
      if (stb.txWe && txWrPtr == PTR_W'(i)) txMem[i] <= hostTxData;
    end
  end

  // Output registers hold their value when no word is popped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastRead <= '0;
      lastSent <= '0;
    end else begin
      if (stb.rxRe) lastRead <= rxMem[rxRdPtr];
      if (stb.txRe) lastSent <= txMem[txRdPtr];
    end
  end

  assign hostRxData = lastRead;
  assign shTxData   = lastSent;
endmodule

// File: rtl/xfer_buffer_pair.sv
module xfer_buffer_pair
  import xfer_buf_pkg::*;
#(
  parameter int W = 32,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hostTxPush,
  input  logic [W-1:0] hostTxData,
  input  logic         hostRxPop,
  output logic [W-1:0] hostRxData,
  input  logic         shRxPush,
  input  logic [W-1:0] shRxData,
  input  logic         shTxPop,
  output logic [W-1:0] shTxData,
  input  logic         hostStatClr,
  input  logic [1:0]   hostStatClrMask,
  output logic         rxFull,
  output logic         rxEmpty,
  output logic         txFull,
  output logic         txEmpty,
  output logic         rdErr,
  output logic         wrErr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  bufStrobe_t       stb;
  logic [PTR_W-1:0] rxWrPtr, rxRdPtr, txWrPtr, txRdPtr;

  xfer_buf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .hostTxPush(hostTxPush), .hostRxPop(hostRxPop),
    .shRxPush(shRxPush), .shTxPop(shTxPop),
    .hostStatClr(hostStatClr), .hostStatClrMask(hostStatClrMask),
    .stb(stb),
    .rxWrPtr(rxWrPtr), .rxRdPtr(rxRdPtr), .txWrPtr(txWrPtr), .txRdPtr(txRdPtr),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .txFull(txFull), .txEmpty(txEmpty),
    .rdErr(rdErr), .wrErr(wrErr)
  );

  xfer_buf_data #(.W(W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .rxWrPtr(rxWrPtr), .rxRdPtr(rxRdPtr), .txWrPtr(txWrPtr), .txRdPtr(txRdPtr),
    .shRxData(shRxData), .hostTxData(hostTxData),
    .hostRxData(hostRxData), .shTxData(shTxData)
  );
endmodule

// File: rtl/xfer_buf_checker.sv
module xfer_buf_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hostRxPop,
  input logic [W-1:0] hostRxData,
  input logic         shRxPush,
  input logic         shTxPop,
  input logic [W-1:0] shTxData,
  input logic         hostStatClr,
  input logic [1:0]   hostStatClrMask,
  input logic         rxFull,
  input logic         rxEmpty,
  input logic         txFull,
  input logic         txEmpty,
  input logic         rdErr,
  input logic         wrErr
);
  assert_ovf_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shRxPush && rxFull) |=> rdErr);

  assert_ovf_keeps_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shRxPush && rxFull && !hostRxPop) |=> rxFull);

  assert_und_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shTxPop && txEmpty) |=> (wrErr && $stable(shTxData)));

  assert_rd_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdErr && !(hostStatClr && hostStatClrMask[0])) |=> rdErr);

  assert_wr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrErr && !(hostStatClr && hostStatClrMask[1])) |=> wrErr);

  assert_empty_pop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hostRxPop && rxEmpty && !shRxPush) |=> ($stable(hostRxData) && rxEmpty));

  assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rxFull && rxEmpty) && !(txFull && txEmpty));
endmodule

bind xfer_buffer_pair xfer_buf_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hostRxPop(hostRxPop), .hostRxData(hostRxData),
  .shRxPush(shRxPush), .shTxPop(shTxPop), .shTxData(shTxData),
  .hostStatClr(hostStatClr), .hostStatClrMask(hostStatClrMask),
  .rxFull(rxFull), .rxEmpty(rxEmpty), .txFull(txFull), .txEmpty(txEmpty),
  .rdErr(rdErr), .wrErr(wrErr)
);

// File: tb/test_xfer_buffer_pair.sv
`timescale 1ns/1ps
module test_xfer_buffer_pair;
  localparam int W = 32;
  localparam int DEPTH = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hostTxPush = 0, hostRxPop = 0, shRxPush = 0, shTxPop = 0, hostStatClr = 0;
  logic [1:0] hostStatClrMask = '0;
  logic [W-1:0] hostTxData = '0, shRxData = '0, hostRxData, shTxData;
  logic rxFull, rxEmpty, txFull, txEmpty, rdErr, wrErr;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  logic [W-1:0] mRx[$], mTx[$];
  logic [W-1:0] mLastRead = '0, mLastSent = '0;
  bit mRdErr = 0, mWrErr = 0;

  always #5 clk = ~clk;

  xfer_buffer_pair #(.W(W), .DEPTH(DEPTH)) i_xfer_buffer_pair (.*);

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit expFull(input int n);  return n == DEPTH; endfunction
  function automatic bit expEmpty(input int n); return n == 0;     endfunction

  task automatic checkAll(input string tag);
    chk(tag, "rxFull",  W'(rxFull),  W'(expFull(mRx.size())));
    chk(tag, "rxEmpty", W'(rxEmpty), W'(expEmpty(mRx.size())));
    chk(tag, "txFull",  W'(txFull),  W'(expFull(mTx.size())));
    chk(tag, "txEmpty", W'(txEmpty), W'(expEmpty(mTx.size())));
    chk(tag, "rdErr",   W'(rdErr),   W'(mRdErr));
    chk(tag, "wrErr",   W'(wrErr),   W'(mWrErr));
    chk(tag, "hostRxData", hostRxData, mLastRead);
    chk(tag, "shTxData",   shTxData,   mLastSent);
  endtask

  // Reference model from the requirements; occupancy taken at start of cycle
  task automatic modelStep(input bit tP, input logic [W-1:0] tD, input bit rP,
                           input bit sP, input logic [W-1:0] sD, input bit sT,
                           input bit clr, input logic [1:0] msk);
    bit rxWasFull = expFull(mRx.size());
    bit rxWasEmpty = expEmpty(mRx.size());
    bit txWasFull = expFull(mTx.size());
    bit txWasEmpty = expEmpty(mTx.size());
    bit ovf = sP && rxWasFull;
    bit und = sT && txWasEmpty;
    if (rP && !rxWasEmpty) mLastRead = mRx.pop_front();
    if (sP && !rxWasFull)  mRx.push_back(sD);
    if (sT && !txWasEmpty) mLastSent = mTx.pop_front();
    if (tP && !txWasFull)  mTx.push_back(tD);
    mRdErr = ovf || (mRdErr && !(clr && msk[0]));
    mWrErr = und || (mWrErr && !(clr && msk[1]));
  endtask

  task automatic step(input string tag, input bit tP, input logic [W-1:0] tD, input bit rP,
                      input bit sP, input logic [W-1:0] sD, input bit sT,
                      input bit clr = 0, input logic [1:0] msk = 2'b00);
    @(negedge clk);
    hostTxPush = tP; hostTxData = tD; hostRxPop = rP;
    shRxPush = sP; shRxData = sD; shTxPop = sT;
    hostStatClr = clr; hostStatClrMask = msk;
    @(posedge clk);
    #1;
    modelStep(tP, tD, rP, sP, sD, sT, clr, msk);
    checkAll(tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checkAll("R8");

    // R1/R2: fill receive buffer, then overflow; stored words survive in order
    step("R1", 0, 0, 0, 1, 32'hA1, 0);
    step("R1", 0, 0, 0, 1, 32'hA2, 0);
    step("R2", 0, 0, 0, 1, 32'hDEAD, 0);
    step("R2", 0, 0, 1, 1, 32'hBEEF, 0);   // overflow with same-cycle pop still drops
    step("R2", 0, 0, 1, 0, 0, 0);
    step("R6", 0, 0, 1, 0, 0, 0);           // pop of empty buffer holds data
    step("R6", 0, 0, 1, 0, 0, 0);
    // R7: clear only masked flag, then clear rdErr
    step("R7", 0, 0, 0, 0, 0, 0, 1, 2'b10);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 2'b01);

    // R4: underflow repeats last word (zero after reset), same-cycle push lands
    step("R4", 0, 0, 0, 0, 0, 1);
    step("R4", 1, 32'hC1, 0, 0, 0, 1);
    step("R5", 0, 0, 0, 0, 0, 1);
    step("R4", 0, 0, 0, 0, 0, 1);
    // R3: push into full transmit buffer is dropped without error
    step("R3", 1, 32'hC2, 0, 0, 0, 0);
    step("R3", 1, 32'hC3, 0, 0, 0, 0);
    step("R3", 1, 32'hFF, 0, 0, 0, 0, 1, 2'b11);
    step("R3", 0, 0, 0, 0, 0, 1);
    // R9: push and pop together with one stored word
    step("R9", 1, 32'hC4, 0, 0, 0, 1);
    step("R9", 0, 0, 0, 0, 0, 1);
    step("R4", 0, 0, 0, 0, 0, 1);
    // R7: error and clear in the same cycle keeps the flag set
    step("R7", 0, 0, 0, 0, 0, 1, 1, 2'b10);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 2'b11);

    // Seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      bit tP = ($urandom % 100) < 45;
      bit rP = ($urandom % 100) < 40;
      bit sP = ($urandom % 100) < 45;
      bit sT = ($urandom % 100) < 40;
      bit cl = ($urandom % 100) < 8;
      step("R1", tP, $urandom, rP, sP, $urandom, sT, cl, 2'($urandom));
    end
    summary();
  end
endmodule